// File: doc/BRIEF.md
# Mesh Router Route and Virtual-Channel Allocator

This block sets up wormhole connections in a five-port mesh router. The ports are local, north, east, south and west. Every input port has its own dimension-ordered route logic. When a header arrives, that logic turns the packet's destination coordinates into an output port. The resulting requests enter a single arrival-ordered queue. Each cycle the request at the head of the queue looks for a free virtual channel (VC) on its output in a central busy table. If one is free, the lowest-numbered free VC is marked busy and a one-cycle grant goes back to the input that asked.

The allocation stays in the table until the packet's tail flit passes. The input port then pulses a release strobe naming its own input VC. The block looks up which output VC that input VC holds and frees it. The crossbar datapath and the credit accounting sit outside this block. Each input port issues one header request at a time and waits for its grant before issuing another.

Top module: `xyva_unit`

## Requirements
- R1: After reset no grant is asserted and every output VC is free, so the first request to any output receives VC 0.
- R2: With the router at (MY_X, MY_Y) and a header bound for (X, Y), the output is chosen in this order. X greater than MY_X selects east (port code 2) and X less than MY_X selects west (4). When X equals MY_X, Y greater than MY_Y selects south (3) and Y less than MY_Y selects north (1). When both coordinates match, the output is local (0).
- R3: Each input port routes its own header. Headers presented on several inputs in the same cycle are all accepted and each is granted its own correct output.
- R4: Requests are served in arrival order. Requests that arrive in the same cycle are queued in ascending input-port index.
- R5: At most one grant is issued per cycle, and it lasts one cycle. With an empty queue and a free VC, the grant appears in the cycle after the request.
- R6: The granted VC is the lowest-numbered free VC on the chosen output, and it is marked busy from the next cycle on.
- R7: When the head request finds no free VC, it stays at the head and is retried every cycle. Later requests do not overtake it, even when they target a different output.
- R8: A release strobe on an input VC that holds a connection frees the output VC of that connection. A head request waiting for that output VC is granted in the cycle after the release.
- R9: A release strobe on an input VC that holds no connection has no effect on the busy table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 5 | Per-input header request strobe (one cycle) |
| req_ivc | input | 5 x VCW | Input VC carrying the header |
| req_dst_x | input | 5 x CW | Destination X coordinate of the header |
| req_dst_y | input | 5 x CW | Destination Y coordinate of the header |
| tail_valid | input | 5 | Per-input tail release strobe |
| tail_ivc | input | 5 x VCW | Input VC whose packet ended |
| gnt_valid | output | 5 | One-cycle grant, one bit per input |
| gnt_port | output | 5 x 3 | Granted output port code (0 local, 1 north, 2 east, 3 south, 4 west) |
| gnt_ovc | output | 5 x VCW | Granted output VC |

## Verification
A request is registered into the queue at the edge that samples it. With the queue empty and a VC free, the grant register is loaded at the following edge, so the grant is visible two sampling points after the request is driven. Each further queued request is granted one cycle after the one before it. A release takes effect at the edge that samples it, and a head request waiting on that VC is granted one edge later. The bench drives inputs on the falling edge and samples on the falling edge that follows the edge at which each result is due. Stalls are checked by confirming that no grant appears at those same sampling points.

// File: rtl/xyva_pkg.sv
package xyva_pkg;
  localparam int NPORT = 5;
  localparam int PW    = 3;

  typedef enum logic [PW-1:0] {
    PORT_LOCAL = 3'd0,
    PORT_NORTH = 3'd1,
    PORT_EAST  = 3'd2,
    PORT_SOUTH = 3'd3,
    PORT_WEST  = 3'd4
  } port_e;
endpackage

// File: rtl/xyva_xy_route.sv
module xyva_xy_route
  import xyva_pkg::*;
#(
  parameter int CW   = 4,
  parameter int MY_X = 3,
  parameter int MY_Y = 4
) (
  input  logic [CW-1:0] dst_x,
  input  logic [CW-1:0] dst_y,
  output logic [PW-1:0] out_port
);
  localparam logic [CW-1:0] HOME_X = CW'(MY_X);
  localparam logic [CW-1:0] HOME_Y = CW'(MY_Y);

  // X dimension first, Y only after X matches
  function automatic logic [PW-1:0] pick_dir(input logic [CW-1:0] x, input logic [CW-1:0] y);
    if (x > HOME_X)      return PORT_EAST;
    else if (x < HOME_X) return PORT_WEST;
    else if (y > HOME_Y) return PORT_SOUTH;
    else if (y < HOME_Y) return PORT_NORTH;
    else                 return PORT_LOCAL;
  endfunction

  assign out_port = pick_dir(dst_x, dst_y);
endmodule

// File: rtl/xyva_arrival_queue.sv
module xyva_arrival_queue
  import xyva_pkg::*;
#(
  parameter int EW = 7,
  localparam int DEPTH = NPORT,
  localparam int CNTW  = $clog2(DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NPORT-1:0]          push,
  input  logic [NPORT-1:0][EW-1:0]  push_data,
  input  logic                      pop,
  output logic                      head_valid,
  output logic [EW-1:0]             head_data,
  output logic [CNTW-1:0]           count
);
  logic [DEPTH-1:0][EW-1:0] q, q_n;
  logic [CNTW-1:0]          cnt, cnt_n;

  always_comb begin
    int idx;
    q_n = q;
    idx = int'(cnt);
    if (pop && cnt != '0) begin
      for (int j = 0; j < DEPTH - 1; j++) q_n[j] = q[j+1];
      idx = idx - 1;
    end
    // ascending input index gives the order among same-cycle arrivals
    for (int i = 0; i < NPORT; i++) begin
      if (push[i] && idx < DEPTH) begin
        q_n[idx] = push_data[i];
        idx = idx + 1;
      end
    end
    cnt_n = CNTW'(idx);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q   <= '0;
      cnt <= '0;
    end else begin
      q   <= q_n;
      cnt <= cnt_n;
    end
  end

  assign head_valid = (cnt != '0);
  assign head_data  = q[0];
  assign count      = cnt;
endmodule

// File: rtl/xyva_vc_table.sv
module xyva_vc_table
  import xyva_pkg::*;
#(
  parameter int NUM_VC = 2,
  localparam int VCW = $clog2(NUM_VC)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        alloc_req,
  input  logic [PW-1:0]               alloc_in,
  input  logic [VCW-1:0]              alloc_ivc,
  input  logic [PW-1:0]               alloc_out,
  input  logic [NPORT-1:0]            tail_valid,
  input  logic [NPORT-1:0][VCW-1:0]   tail_ivc,
  output logic                        alloc_fire,
  output logic [VCW-1:0]              alloc_ovc,
  output logic [NPORT*NUM_VC-1:0]     busy_flat
);
  logic [NPORT-1:0][NUM_VC-1:0]           busy;
  logic [NPORT-1:0][NUM_VC-1:0]           conn_v;
  logic [NPORT-1:0][NUM_VC-1:0][PW-1:0]   conn_out;
  logic [NPORT-1:0][NUM_VC-1:0][VCW-1:0]  conn_ovc;
  logic [NUM_VC-1:0]                      free_vc;

  // lowest-numbered free VC wins
  function automatic logic [VCW-1:0] lowest_set(input logic [NUM_VC-1:0] v);
    logic [VCW-1:0] r;
    r = '0;
    for (int k = NUM_VC - 1; k >= 0; k--) if (v[k]) r = VCW'(k);
    return r;
  endfunction

  assign free_vc    = ~busy[alloc_out];
  assign alloc_fire = alloc_req && (free_vc != '0);
  assign alloc_ovc  = lowest_set(free_vc);
  assign busy_flat  = busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= '0;
      conn_v   <= '0;
      conn_out <= '0;
      conn_ovc <= '0;
    end else begin
      for (int i = 0; i < NPORT; i++) begin
        if (tail_valid[i] && conn_v[i][tail_ivc[i]]) begin
          busy[conn_out[i][tail_ivc[i]]][conn_ovc[i][tail_ivc[i]]] <= 1'b0;
          conn_v[i][tail_ivc[i]] <= 1'b0;
        end
      end
      if (alloc_fire) begin
        busy[alloc_out][alloc_ovc]    <= 1'b1;
        conn_v[alloc_in][alloc_ivc]   <= 1'b1;
        conn_out[alloc_in][alloc_ivc] <= alloc_out;
        conn_ovc[alloc_in][alloc_ivc] <= alloc_ovc;
      end
    end
  end
endmodule

// File: rtl/xyva_unit.sv
module xyva_unit
  import xyva_pkg::*;
#(
  parameter int NUM_VC = 2,
  parameter int CW     = 4,
  parameter int MY_X   = 3,
  parameter int MY_Y   = 4,
  localparam int VCW   = $clog2(NUM_VC)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NPORT-1:0]            req_valid,
  input  logic [NPORT-1:0][VCW-1:0]   req_ivc,
  input  logic [NPORT-1:0][CW-1:0]    req_dst_x,
  input  logic [NPORT-1:0][CW-1:0]    req_dst_y,
  input  logic [NPORT-1:0]            tail_valid,
  input  logic [NPORT-1:0][VCW-1:0]   tail_ivc,
  output logic [NPORT-1:0]            gnt_valid,
  output logic [NPORT-1:0][PW-1:0]    gnt_port,
  output logic [NPORT-1:0][VCW-1:0]   gnt_ovc
);
  localparam int EW   = PW + VCW + PW;
  localparam int CNTW = $clog2(NPORT + 1);

  logic [NPORT-1:0][PW-1:0] route;
  logic [NPORT-1:0][EW-1:0] push_data;
  logic                     head_valid;
  logic [EW-1:0]            head_data;
  logic [CNTW-1:0]          q_count;
  logic [PW-1:0]            head_in, head_out;
  logic [VCW-1:0]           head_ivc;
  logic                     alloc_fire;
  logic [VCW-1:0]           alloc_ovc;
  logic [NPORT*NUM_VC-1:0]  busy_flat;

  for (genvar p = 0; p < NPORT; p++) begin : g_route
    xyva_xy_route #(.CW(CW), .MY_X(MY_X), .MY_Y(MY_Y)) u_route (
      .dst_x   (req_dst_x[p]),
      .dst_y   (req_dst_y[p]),
      .out_port(route[p])
    );
    assign push_data[p] = {PW'(p), req_ivc[p], route[p]};
  end

  xyva_arrival_queue #(.EW(EW)) u_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (req_valid),
    .push_data (push_data),
    .pop       (alloc_fire),
    .head_valid(head_valid),
    .head_data (head_data),
    .count     (q_count)
  );

  assign {head_in, head_ivc, head_out} = head_data;

  xyva_vc_table #(.NUM_VC(NUM_VC)) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc_req (head_valid),
    .alloc_in  (head_in),
    .alloc_ivc (head_ivc),
    .alloc_out (head_out),
    .tail_valid(tail_valid),
    .tail_ivc  (tail_ivc),
    .alloc_fire(alloc_fire),
    .alloc_ovc (alloc_ovc),
    .busy_flat (busy_flat)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt_valid <= '0;
      gnt_port  <= '0;
      gnt_ovc   <= '0;
    end else begin
      gnt_valid <= '0;
      if (alloc_fire) begin
        gnt_valid[head_in] <= 1'b1;
        gnt_port[head_in]  <= head_out;
        gnt_ovc[head_in]   <= alloc_ovc;
      end
    end
  end
endmodule

// File: rtl/xyva_checker.sv
module xyva_checker
  import xyva_pkg::*;
#(
  parameter int NUM_VC = 2,
  localparam int VCW  = $clog2(NUM_VC),
  localparam int CNTW = $clog2(NPORT + 1)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NPORT-1:0]        gnt_valid,
  input logic [CNTW-1:0]         q_count,
  input logic                    alloc_fire,
  input logic [PW-1:0]           alloc_out,
  input logic [VCW-1:0]          alloc_ovc,
  input logic [NPORT*NUM_VC-1:0] busy_flat
);
  assert_one_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_valid));

  assert_grant_from_queue_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid != '0) |-> ($past(q_count) != '0));

  assert_alloc_was_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |-> !busy_flat[int'(alloc_out) * NUM_VC + int'(alloc_ovc)]);

  assert_alloc_marks_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |=> busy_flat[int'($past(alloc_out)) * NUM_VC + int'($past(alloc_ovc))]);

  assert_queue_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    int'(q_count) <= NPORT);
endmodule

bind xyva_unit xyva_checker #(.NUM_VC(NUM_VC)) u_xyva_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .gnt_valid (gnt_valid),
  .q_count   (q_count),
  .alloc_fire(alloc_fire),
  .alloc_out (head_out),
  .alloc_ovc (alloc_ovc),
  .busy_flat (busy_flat)
);

// File: tb/test_xyva_unit.sv
module test_xyva_unit;
  import xyva_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_VC = 2;
  localparam int VCW = 1;
  localparam int CW = 4;
  localparam int HX = 3;
  localparam int HY = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NPORT-1:0]          req_valid = '0;
  logic [NPORT-1:0][VCW-1:0] req_ivc = '0;
  logic [NPORT-1:0][CW-1:0]  req_dst_x = '0;
  logic [NPORT-1:0][CW-1:0]  req_dst_y = '0;
  logic [NPORT-1:0]          tail_valid = '0;
  logic [NPORT-1:0][VCW-1:0] tail_ivc = '0;
  logic [NPORT-1:0]          gnt_valid;
  logic [NPORT-1:0][PW-1:0]  gnt_port;
  logic [NPORT-1:0][VCW-1:0] gnt_ovc;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xyva_unit #(.NUM_VC(NUM_VC), .CW(CW), .MY_X(HX), .MY_Y(HY)) i_xyva_unit (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ivc(req_ivc),
    .req_dst_x(req_dst_x), .req_dst_y(req_dst_y),
    .tail_valid(tail_valid), .tail_ivc(tail_ivc),
    .gnt_valid(gnt_valid), .gnt_port(gnt_port), .gnt_ovc(gnt_ovc)
  );

  // expected direction from signed offsets: 0 local,1 north,2 east,3 south,4 west
  function automatic int want_dir(int x, int y);
    int ddx = x - HX;
    int ddy = y - HY;
    if (ddx != 0) return (ddx > 0) ? 2 : 4;
    if (ddy != 0) return (ddy > 0) ? 3 : 1;
    return 0;
  endfunction

  task automatic tick();
    @(negedge clk);
    req_valid  = '0;
    tail_valid = '0;
  endtask

  task automatic put_req(int p, int vc, int x, int y);
    req_valid[p] = 1'b1;
    req_ivc[p]   = VCW'(vc);
    req_dst_x[p] = CW'(x);
    req_dst_y[p] = CW'(y);
  endtask

  task automatic put_tail(int p, int vc);
    tail_valid[p] = 1'b1;
    tail_ivc[p]   = VCW'(vc);
  endtask

  task automatic expect_grant(string tag, int p, int outp, int ovc);
    n_vec++;
    if (gnt_valid != NPORT'(1 << p) || int'(gnt_port[p]) != outp || int'(gnt_ovc[p]) != ovc) begin
      n_bad++;
      $display("FAIL %s: valid=%b port=%0d ovc=%0d, expected valid=%b port=%0d ovc=%0d",
               tag, gnt_valid, gnt_port[p], gnt_ovc[p], NPORT'(1 << p), outp, ovc);
    end
  endtask

  task automatic expect_none(string tag);
    n_vec++;
    if (gnt_valid != '0) begin
      n_bad++;
      $display("FAIL %s: valid=%b, expected valid=00000", tag, gnt_valid);
    end
  endtask

  task automatic t_reset();
    expect_none("R1 no grant after reset");
  endtask

  task automatic t_route();
    int xs[5] = '{5, 1, 3, 3, 3};
    int ys[5] = '{9, 0, 7, 2, 4};
    for (int k = 0; k < 5; k++) begin
      put_req(0, 0, xs[k], ys[k]);
      tick(); tick();
      expect_grant("R2 xy route, R1 vc0 free", 0, want_dir(xs[k], ys[k]), 0);
      tick();
      expect_none("R5 grant lasts one cycle");
      put_tail(0, 0);
      tick();
    end
  endtask

  task automatic t_exhaust();
    put_req(1, 0, 7, 4); tick(); tick();
    expect_grant("R6 first east vc", 1, 2, 0);
    put_req(2, 1, 9, 0); tick(); tick();
    expect_grant("R6 next lowest east vc", 2, 2, 1);
    put_req(3, 0, 15, 4); tick(); tick();
    expect_none("R7 east exhausted, head waits");
    put_req(4, 0, 3, 0); tick(); tick();
    expect_none("R7 later north request does not overtake");
    put_tail(1, 0); tick(); tick();
    expect_grant("R8 waiting head granted after release", 3, 2, 0);
    tick();
    expect_grant("R7 queued request follows", 4, 1, 0);
    put_tail(2, 1); put_tail(3, 0); put_tail(4, 0); tick();
  endtask

  task automatic t_same_cycle();
    put_req(4, 1, 0, 4); put_req(1, 0, 0, 4);
    tick(); tick();
    expect_grant("R4 lower index first", 1, 4, 0);
    tick();
    expect_grant("R4 higher index second", 4, 4, 1);
    put_tail(1, 0); put_tail(4, 1); tick();
  endtask

  task automatic t_arrival_order();
    put_req(3, 0, 3, 8); tick();
    put_req(0, 1, 3, 8); tick();
    expect_grant("R4 earlier arrival first", 3, 3, 0);
    tick();
    expect_grant("R4 later arrival second", 0, 3, 1);
    put_tail(3, 0); put_tail(0, 1); tick();
  endtask

  task automatic t_parallel_route();
    put_req(0, 0, 12, 1); put_req(2, 0, 2, 15); put_req(4, 1, 3, 4);
    tick(); tick();
    expect_grant("R3 input0 east", 0, 2, 0);
    tick();
    expect_grant("R3 input2 west", 2, 4, 0);
    tick();
    expect_grant("R3 input4 local", 4, 0, 0);
    put_tail(0, 0); put_tail(2, 0); put_tail(4, 1); tick();
  endtask

  task automatic t_stray_release();
    put_req(0, 0, 7, 4); tick(); tick();
    expect_grant("R9 setup east vc0", 0, 2, 0);
    put_req(1, 1, 7, 4); tick(); tick();
    expect_grant("R9 setup east vc1", 1, 2, 1);
    put_tail(2, 1); put_tail(3, 0); tick();
    put_req(3, 0, 8, 4); tick(); tick();
    expect_none("R9 stray release frees nothing");
    put_tail(0, 0); tick(); tick();
    expect_grant("R8 real release frees vc0", 3, 2, 0);
    put_tail(1, 1); put_tail(3, 0); tick();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_route();
    t_exhaust();
    t_same_cycle();
    t_arrival_order();
    t_parallel_route();
    t_stray_release();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule